// File: doc/BRIEF.md
# Monochrome Glyph Expansion Blitter

This block turns one-bit-per-pixel glyph data into 8-bit pixels for a frame buffer. Software uses a register write port to program a foreground colour, a background colour, a plane mask, a horizontal step, a row and a start and end column. It then writes a 32-bit glyph word. That write starts the expansion of one row span of up to 32 pixels. Each pixel is offered on a pixel write port toward frame-buffer memory, with the plane mask as a per-bit write enable.

Both the register port and the pixel port use valid/ready handshakes. A register write is taken on a clock edge where `reg_valid` and `reg_ready` are both high. `reg_ready` is low only when a glyph word arrives while the block is busy, so the word waits and is not lost. All other registers may be written at any time. The memory side takes a pixel on an edge where `pix_valid` and `pix_ready` are both high. While `pix_ready` is low, the offered pixel and its address stay unchanged. `busy` is a plain level output that software polls before it reprograms the block. Column clip limits should only be changed while `busy` is low.

A typical text renderer works as follows. It sets the step to 32, writes the start column of a character row, and then writes one glyph word after another. The start column moves on by itself after each word.

Top module: `glyph_expander`

## Requirements
- R1: A glyph word accepted at register address 9 draws pixels at columns start..end inclusive, all on the programmed row. The row is at address 4, the start column at address 5 and the end column at address 6.
- R2: Glyph bit 31 maps to the start column. Each lower bit maps to the next column to the right.
- R3: A set glyph bit gives a pixel value equal to the foreground register (address 0). A clear bit gives the background register (address 1).
- R4: A span is clamped to 32 pixels. Glyph bits beyond the span length are ignored. If end < start, nothing is drawn and `busy` stays low.
- R5: Every accepted glyph word adds the step register (address 3) to the start column. The step resets to 32.
- R6: `busy` is high from the cycle after a glyph word with a non-empty span is accepted. It drops in the cycle after the last span position is handled.
- R7: `pix_mask` carries the plane mask (address 2, reset 0xFF) that was in force when the glyph word was accepted. A 1 bit allows that pixel bit to be written.
- R8: A column below clip-low (address 7, reset 0) or above clip-high (address 8, reset 0xFFFF) is never offered on the pixel port. It still uses up its glyph bit.
- R9: At most one pixel moves per clock. While `pix_valid` is high and `pix_ready` is low, the offered column and pixel value stay stable.
- R10: A glyph word written while busy sees `reg_ready` low until the span ends, and is then accepted. Writes to other addresses are accepted while busy.
- R11: After reset, `busy` and `pix_valid` are low, `pix_mask` is 0xFF, and the start and end columns are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register write request |
| reg_ready | output | 1 | Register write can be taken this cycle |
| reg_addr | input | 4 | Register address (0..9) |
| reg_wdata | input | 32 | Register write data; coordinates and colours use the low bits |
| busy | output | 1 | A span is being expanded |
| pix_valid | output | 1 | Pixel write offered |
| pix_ready | input | 1 | Memory accepts the offered pixel |
| pix_x | output | 16 | Pixel column |
| pix_y | output | 16 | Pixel row |
| pix_data | output | 8 | Pixel value |
| pix_mask | output | 8 | Per-bit write enable (plane mask) |

## Verification
Suppose a glyph word is accepted on clock edge k. Then `busy` and the first span position are visible in the cycle after k. Each further pixel follows one cycle after the previous handshake, or one cycle after a clipped position. `busy` is low in the cycle that follows the final handshake. The bench drives inputs at falling edges and samples at falling edges. It checks `busy` at the falling edge right after the glyph acceptance and at the falling edge after the last pixel handshake. A scoreboard compares each pixel in handshake order, so back-pressure changes only when a result arrives, never what it is.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int GX_ADDR_W = 4;

  typedef enum logic [GX_ADDR_W-1:0] {
    GA_FG     = 4'd0,
    GA_BG     = 4'd1,
    GA_PMASK  = 4'd2,
    GA_XSTEP  = 4'd3,
    GA_ROW    = 4'd4,
    GA_XSTART = 4'd5,
    GA_XEND   = 4'd6,
    GA_CLIPLO = 4'd7,
    GA_CLIPHI = 4'd8,
    GA_GLYPH  = 4'd9
  } gx_addr_e;
endpackage

// File: rtl/gx_regs.sv
module gx_regs
  import gx_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8,
  parameter int GLYPH_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [GX_ADDR_W-1:0] addr,
  input  logic [GLYPH_W-1:0]   wdata,
  output logic [PIX_W-1:0]     fg,
  output logic [PIX_W-1:0]     bg,
  output logic [PIX_W-1:0]     pm,
  output logic [COORD_W-1:0]   row,
  output logic [COORD_W-1:0]   xstart,
  output logic [COORD_W-1:0]   xend,
  output logic [COORD_W-1:0]   clip_lo,
  output logic [COORD_W-1:0]   clip_hi
);
  logic [COORD_W-1:0] xstep;
  logic               unused_hi;
  assign unused_hi = ^wdata[GLYPH_W-1:COORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fg      <= '0;
      bg      <= '0;
      pm      <= '1;
      xstep   <= COORD_W'(GLYPH_W);
      row     <= '0;
      xstart  <= '0;
      xend    <= '0;
      clip_lo <= '0;
      clip_hi <= '1;
    end else if (wr_en) begin
      case (gx_addr_e'(addr))
        GA_FG:     fg      <= wdata[PIX_W-1:0];
        GA_BG:     bg      <= wdata[PIX_W-1:0];
        GA_PMASK:  pm      <= wdata[PIX_W-1:0];
        GA_XSTEP:  xstep   <= wdata[COORD_W-1:0];
        GA_ROW:    row     <= wdata[COORD_W-1:0];
        GA_XSTART: xstart  <= wdata[COORD_W-1:0];
        GA_XEND:   xend    <= wdata[COORD_W-1:0];
        GA_CLIPLO: clip_lo <= wdata[COORD_W-1:0];
        GA_CLIPHI: clip_hi <= wdata[COORD_W-1:0];
        GA_GLYPH:  xstart  <= xstart + xstep;
        default:   ;
      endcase
    end
  end

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == GA_GLYPH) |=> xstart == $past(xstart) + $past(xstep));
endmodule

// File: rtl/gx_span_len.sv
module gx_span_len #(
  parameter int COORD_W = 16,
  parameter int GLYPH_W = 32,
  parameter int CNT_W   = 6
) (
  input  logic [COORD_W-1:0] xstart,
  input  logic [COORD_W-1:0] xend,
  output logic [CNT_W-1:0]   count
);
  logic [COORD_W-1:0] diff;
  logic               unused_diff;
  assign diff        = xend - xstart;
  assign unused_diff = ^diff[COORD_W-1:CNT_W];

  always_comb begin
    if (xend < xstart)
      count = '0;
    else if (diff >= COORD_W'(GLYPH_W - 1))
      count = CNT_W'(GLYPH_W);
    else
      count = diff[CNT_W-1:0] + CNT_W'(1);
  end
endmodule

// File: rtl/gx_engine.sv
module gx_engine #(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8,
  parameter int GLYPH_W = 32,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   count_in,
  input  logic [GLYPH_W-1:0] word_in,
  input  logic [COORD_W-1:0] x_in,
  input  logic [COORD_W-1:0] y_in,
  input  logic [PIX_W-1:0]   fg_in,
  input  logic [PIX_W-1:0]   bg_in,
  input  logic [PIX_W-1:0]   pm_in,
  input  logic [COORD_W-1:0] clip_lo,
  input  logic [COORD_W-1:0] clip_hi,
  output logic               busy,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] pix_y,
  output logic [PIX_W-1:0]   pix_data,
  output logic [PIX_W-1:0]   pix_mask
);
  logic               active;
  logic [CNT_W-1:0]   left;
  logic [COORD_W-1:0] cx, cy;
  logic [GLYPH_W-1:0] word;
  logic [PIX_W-1:0]   fg, bg, pm;
  logic               in_clip, advance;

  assign in_clip = (cx >= clip_lo) && (cx <= clip_hi);
  assign advance = active && (!in_clip || pix_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
      cx     <= '0;
      cy     <= '0;
      word   <= '0;
      fg     <= '0;
      bg     <= '0;
      pm     <= '1;
    end else if (start && count_in != '0) begin
      active <= 1'b1;
      left   <= count_in;
      cx     <= x_in;
      cy     <= y_in;
      word   <= word_in;
      fg     <= fg_in;
      bg     <= bg_in;
      pm     <= pm_in;
    end else if (advance) begin
      left <= left - CNT_W'(1);
      cx   <= cx + COORD_W'(1);
      word <= word << 1;
      if (left == CNT_W'(1)) active <= 1'b0;
    end
  end

  for (genvar g = 0; g < PIX_W; g++) begin : g_plane
    assign pix_data[g] = word[GLYPH_W-1] ? fg[g] : bg[g];
  end

  assign busy      = active;
  assign pix_valid = active && in_clip;
  assign pix_x     = cx;
  assign pix_y     = cy;
  assign pix_mask  = pm;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_data)));
  // R2
  xorder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> (!pix_valid || pix_x > $past(pix_x)));
  // R7
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(pix_mask)));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && count_in != '0) |=> busy);
  // R4
  empty_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && count_in == '0 && !busy) |=> !busy);
endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
  import gx_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PIX_W   = 8,
  parameter int GLYPH_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_valid,
  output logic                 reg_ready,
  input  logic [GX_ADDR_W-1:0] reg_addr,
  input  logic [GLYPH_W-1:0]   reg_wdata,
  output logic                 busy,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic [COORD_W-1:0]   pix_x,
  output logic [COORD_W-1:0]   pix_y,
  output logic [PIX_W-1:0]     pix_data,
  output logic [PIX_W-1:0]     pix_mask
);
  localparam int CNT_W = $clog2(GLYPH_W + 1);

  logic               is_glyph, wr_en, fire;
  logic [PIX_W-1:0]   fg, bg, pm;
  logic [COORD_W-1:0] row, xstart, xend, clip_lo, clip_hi;
  logic [CNT_W-1:0]   count;

  assign is_glyph  = (reg_addr == GA_GLYPH);
  assign reg_ready = !(busy && is_glyph);
  assign wr_en     = reg_valid && reg_ready;
  assign fire      = wr_en && is_glyph;

  gx_regs #(.COORD_W(COORD_W), .PIX_W(PIX_W), .GLYPH_W(GLYPH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .fg(fg), .bg(bg), .pm(pm), .row(row), .xstart(xstart), .xend(xend),
    .clip_lo(clip_lo), .clip_hi(clip_hi)
  );

  gx_span_len #(.COORD_W(COORD_W), .GLYPH_W(GLYPH_W), .CNT_W(CNT_W)) u_len (
    .xstart(xstart), .xend(xend), .count(count)
  );

  gx_engine #(.COORD_W(COORD_W), .PIX_W(PIX_W), .GLYPH_W(GLYPH_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(fire), .count_in(count), .word_in(reg_wdata),
    .x_in(xstart), .y_in(row), .fg_in(fg), .bg_in(bg), .pm_in(pm),
    .clip_lo(clip_lo), .clip_hi(clip_hi), .busy(busy),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
    .pix_data(pix_data), .pix_mask(pix_mask)
  );

  // R1
  span_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && count != '0) |=> (pix_x == $past(xstart) && pix_y == $past(row)));
endmodule

// File: tb/test_glyph_expander.sv
module test_glyph_expander;
  import gx_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_ready;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, pix_valid;
  logic        pix_ready = 1'b1;
  logic [15:0] pix_x, pix_y;
  logic [7:0]  pix_data, pix_mask;

  always #5 clk = ~clk;

  glyph_expander i_glyph_expander (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_ready(reg_ready),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
    .pix_data(pix_data), .pix_mask(pix_mask)
  );

  int n_chk = 0, n_bad = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  bit          drop_en = 1'b1;
  bit          rnd_mode = 1'b0;
  logic [7:0]  lfsr = 8'hA7;

  logic [7:0]  m_fg = '0, m_bg = '0, m_pm = 8'hFF;
  logic [15:0] m_xs = 16'd32, m_y = '0, m_x0 = '0, m_x1 = '0, m_lo = '0, m_hi = 16'hFFFF;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output int waits);
    @(negedge clk);
    reg_valid = 1'b1; reg_addr = a; reg_wdata = d; waits = 0;
    #1;
    while (!reg_ready) begin @(negedge clk); #1; waits++; end
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic setr(input logic [3:0] a, input logic [31:0] d);
    int wt;
    wr(a, d, wt);
    case (a)
      4'd0: m_fg = d[7:0];
      4'd1: m_bg = d[7:0];
      4'd2: m_pm = d[7:0];
      4'd3: m_xs = d[15:0];
      4'd4: m_y  = d[15:0];
      4'd5: m_x0 = d[15:0];
      4'd6: m_x1 = d[15:0];
      4'd7: m_lo = d[15:0];
      4'd8: m_hi = d[15:0];
      default: ;
    endcase
  endtask

  task automatic glyph(input logic [31:0] w, input string tag, output int waits);
    int n;
    logic [15:0] d, x;
    if (m_x1 < m_x0) n = 0;
    else begin d = m_x1 - m_x0; n = (d >= 16'd31) ? 32 : int'(d) + 1; end
    for (int i = 0; i < n; i++) begin
      x = m_x0 + 16'(i);
      if (x >= m_lo && x <= m_hi) begin
        exp_q.push_back({x, m_y, (w[31-i] ? m_fg : m_bg), m_pm});
        tag_q.push_back(tag);
      end
    end
    wr(4'(GA_GLYPH), w, waits);
    m_x0 = m_x0 + m_xs;
    chk(busy == (n != 0), (n != 0) ? "R6" : "R4", "busy after glyph accept",
        64'(busy), 64'(n != 0));
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || busy);
  endtask

  // ready driver
  initial forever begin
    @(posedge clk); #2;
    pix_ready = rnd_mode ? lfsr[0] : 1'b1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  // monitor / scoreboard
  initial begin
    bit stall = 1'b0, drop_pend = 1'b0;
    logic [15:0] px; logic [7:0] pd;
    logic [47:0] e; string t;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (drop_pend) chk(!busy, "R6", "busy after last pixel", 64'(busy), 0);
        drop_pend = 1'b0;
        if (stall)
          chk(pix_valid && pix_x == px && pix_data == pd, "R9", "stalled pixel held",
              {pix_valid, pix_x, pix_data}, {1'b1, px, pd});
        stall = pix_valid && !pix_ready;
        px = pix_x; pd = pix_data;
        if (pix_valid && pix_ready) begin
          if (exp_q.size() == 0) chk(0, "R8", "unexpected pixel", 64'(pix_x), 0);
          else begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            chk({pix_x, pix_y, pix_data, pix_mask} == e, t, "pixel x/y/data/mask",
                {pix_x, pix_y, pix_data, pix_mask}, e);
            if (exp_q.size() == 0 && drop_en) drop_pend = 1'b1;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int wt;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy, "R11", "busy in reset", 64'(busy), 0);
    chk(!pix_valid, "R11", "pix_valid in reset", 64'(pix_valid), 0);
    chk(pix_mask == 8'hFF, "R11", "mask in reset", 64'(pix_mask), 64'hFF);
    rst_n = 1'b1;

    // R1 R2 R3: full word
    setr(0, 32'h5A); setr(1, 32'h11); setr(4, 3); setr(5, 10); setr(6, 41);
    glyph(32'hA5C3_0F81, "R1/R2/R3", wt);
    // R10 other registers while busy, glyph waits; R5 start advanced to 42
    setr(6, 73);
    chk(busy, "R10", "still busy after end-column write", 64'(busy), 1);
    glyph(32'hFFFF_0000, "R5/R10", wt);
    chk(wt > 0, "R10", "glyph held while busy (wait cycles)", 64'(wt), 1);
    drain();

    // R4 partial span, low bits ignored
    setr(5, 100); setr(6, 104);
    glyph(32'hB8FF_FFFF, "R4", wt); drain();
    // R4 oversize span clamps to 32
    setr(5, 300); setr(6, 340);
    glyph(32'h0F0F_0F0F, "R4", wt); drain();
    // R4 empty span, then R5 advance verified by next word
    setr(5, 500); setr(6, 499);
    glyph(32'hFFFF_FFFF, "R4", wt);
    repeat (3) @(negedge clk);
    chk(!busy && !pix_valid, "R4", "empty span idle", {busy, pix_valid}, 0);
    setr(6, 535);
    glyph(32'hF000_0000, "R5", wt); drain();

    // R7 plane mask, R5 custom step
    setr(2, 32'h0F); setr(3, 8); setr(4, 9); setr(5, 600); setr(6, 607);
    glyph(32'h8100_0000, "R7", wt); drain();
    setr(6, 615);
    glyph(32'h7E00_0000, "R5/R7", wt); drain();
    setr(2, 32'hFF); setr(3, 32);

    // R8 clip window, trailing positions clipped
    drop_en = 1'b0;
    setr(7, 205); setr(8, 215); setr(5, 200); setr(6, 231);
    glyph(32'h1234_5678, "R8", wt); drain();
    setr(7, 0); setr(8, 32'hFFFF);
    drop_en = 1'b1;

    // R9 back-pressure
    rnd_mode = 1'b1;
    setr(0, 32'hC3); setr(1, 32'h3C); setr(5, 700); setr(6, 731);
    glyph(32'hDEAD_BEEF, "R9", wt);
    setr(6, 763);
    glyph(32'h0123_4567, "R9", wt); drain();
    rnd_mode = 1'b0;

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "scoreboard empty", 64'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule